// File: doc/BRIEF.md
# Multi-Stream Sequential Prefetch Buffer

This block sits between a first-level cache and a pipelined next memory level. It holds several small FIFO buffers, each following one sequential stream of cache-line addresses. When the cache misses, it presents the line address to the block. If that address equals the oldest entry of one of the buffers, the block returns the line and that buffer asks the lower level for the next line of its stream. Prefetched lines stay inside the buffers until a miss claims them and are never pushed into the cache unasked.

A miss that matches no buffer head is answered at once as a miss, so the cache fetches that line itself. The least-recently-used buffer is then flushed and refilled starting one line past the missing address. Each buffer keeps up to `DEPTH` requests in flight. Every request carries an identifier naming the buffer, the slot and an allocation epoch, and a fill returned for an allocation that has since been flushed is dropped.

Top module: `spb_prefetch`

## Requirements
- R1: After reset `miss_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A miss accepted when no live buffer head equals `miss_addr` gives, on the next cycle, `rsp_valid`=1 and `rsp_hit`=0. The least-recently-used buffer is then restarted at `miss_addr`+1. After reset buffer 0 is the least recently used, then buffer 1, and so on. The restarted buffer requests lines `miss_addr`+1 up to `miss_addr`+`DEPTH` in that order, using slots 0 up to `DEPTH`-1. `mem_req_id` is {buffer, slot, epoch}: the epoch is in the low `EPOCH_W` bits, the slot is above it and the buffer index is in the top bits. A buffer's epoch starts at 0 and increases by one on each restart.
- R3: A prefetched line reaches the cache only through a hit response, and its data equals the fill returned for that line address.
- R4: A miss that equals a buffer head whose data is present is answered on the next cycle with `rsp_hit`=1 and that line's data.
- R5: Returning a head line frees its slot, and that slot then requests the popped address plus `DEPTH`.
- R6: A miss that equals a head whose fill has not arrived holds `miss_ready` and `rsp_valid` low. When the fill is taken at a clock edge, the hit response appears after the following edge.
- R7: Only buffer heads are compared. A miss equal to a non-head entry is answered as a miss.
- R8: A fill whose epoch is not the buffer's current epoch has no effect. A later miss on that slot's line still waits for the matching fill.
- R9: Independent buffers follow interleaved streams, so alternating misses on two sequential streams all hit after each stream's first miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache miss lookup request |
| miss_addr | input | LA_W | Missing line address |
| miss_ready | output | 1 | Block can take a lookup |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Line found in a buffer head |
| rsp_data | output | DATA_W | Line data on a hit |
| mem_req_valid | output | 1 | Line request to next level |
| mem_req_ready | input | 1 | Next level takes the request |
| mem_req_addr | output | LA_W | Requested line address |
| mem_req_id | output | BUF_W+SLOT_W+EPOCH_W | Buffer, slot and epoch identifier |
| mem_rsp_valid | input | 1 | Fill from next level |
| mem_rsp_id | input | BUF_W+SLOT_W+EPOCH_W | Identifier of the fill |
| mem_rsp_data | input | DATA_W | Fill line data |

## Verification
The bench builds the block with two buffers of four slots, 16-bit line addresses and data, and a 2-bit epoch. With only two buffers, a few misses force replacement of either buffer, and with four slots a single stream wraps the FIFO many times during a sweep. The fill responder in the bench can be switched from automatic in-order replies to hand-placed fills. This makes it possible to time a stalled head hit to the exact edge and to inject a stale-epoch fill into the very slot that a new allocation occupies.

// File: rtl/spb_pkg.sv
package spb_pkg;

    // State of one buffer slot
    typedef enum logic [1:0] {
        SL_FREE = 2'd0,   // never allocated
        SL_WANT = 2'd1,   // line address known, request not yet sent
        SL_PEND = 2'd2,   // request sent, fill outstanding
        SL_FULL = 2'd3    // line data present
    } slot_st_e;

    // Lookup engine state
    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_WAIT = 1'b1
    } lk_st_e;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/spb_pick.sv
module spb_pick #(
    parameter int N = 4,
    localparam int W = spb_pkg::idx_bits(N)
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    // Fixed priority: lowest index wins
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (!any_o && req_i[i]) begin
                any_o = 1'b1;
                idx_o = W'(i);
            end
        end
    end
endmodule

// File: rtl/spb_lru.sv
module spb_lru #(
    parameter int NBUF = 4,
    localparam int W = spb_pkg::idx_bits(NBUF)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         touch_i,
    input  logic [W-1:0] touch_idx_i,
    output logic [W-1:0] victim_o
);
    // Rank 0 = most recent, NBUF-1 = least recent
    logic [W-1:0] rank_q [NBUF];

    always_comb begin
        victim_o = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (rank_q[i] == W'(NBUF - 1)) victim_o = W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) rank_q[i] <= W'(NBUF - 1 - i);
        end else if (touch_i) begin
            for (int i = 0; i < NBUF; i++) begin
                if (W'(i) == touch_idx_i)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx_i])
                    rank_q[i] <= rank_q[i] + W'(1);
            end
        end
    end
endmodule

// File: rtl/spb_stream.sv
module spb_stream
    import spb_pkg::*;
#(
    parameter int LA_W    = 26,
    parameter int DATA_W  = 64,
    parameter int DEPTH   = 4,
    parameter int EPOCH_W = 2,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_i,
    input  logic [LA_W-1:0]    alloc_base_i,
    input  logic               pop_i,
    input  logic               issue_i,
    input  logic               fill_i,
    input  logic [SLOT_W-1:0]  fill_slot_i,
    input  logic [EPOCH_W-1:0] fill_epoch_i,
    input  logic [DATA_W-1:0]  fill_data_i,
    output logic               head_live_o,
    output logic               head_full_o,
    output logic [LA_W-1:0]    head_addr_o,
    output logic [DATA_W-1:0]  head_data_o,
    output logic               want_o,
    output logic [SLOT_W-1:0]  want_slot_o,
    output logic [LA_W-1:0]    want_addr_o,
    output logic [EPOCH_W-1:0] epoch_o
);
    slot_st_e            st_q   [DEPTH];
    logic [LA_W-1:0]     addr_q [DEPTH];
    logic [DATA_W-1:0]   data_q [DEPTH];
    logic [SLOT_W-1:0]   head_q;
    logic [EPOCH_W-1:0]  epoch_q;

    assign head_live_o = (st_q[head_q] != SL_FREE);
    assign head_full_o = (st_q[head_q] == SL_FULL);
    assign head_addr_o = addr_q[head_q];
    assign head_data_o = data_q[head_q];
    assign epoch_o     = epoch_q;

    // Oldest slot still waiting to be requested, scanning from the head
    always_comb begin
        want_o      = 1'b0;
        want_slot_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [SLOT_W-1:0] s;
            s = head_q + SLOT_W'(k);
            if (!want_o && st_q[s] == SL_WANT) begin
                want_o      = 1'b1;
                want_slot_o = s;
            end
        end
    end
    assign want_addr_o = addr_q[want_slot_o];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            epoch_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]   <= SL_FREE;
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else if (alloc_i) begin
            // Restart: every slot reloaded, in-flight fills become stale
            head_q  <= '0;
            epoch_q <= epoch_q + EPOCH_W'(1);
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]   <= SL_WANT;
                addr_q[i] <= alloc_base_i + LA_W'(i);
            end
        end else begin
            if (issue_i)
                st_q[want_slot_o] <= SL_PEND;
            if (fill_i && st_q[fill_slot_i] == SL_PEND && fill_epoch_i == epoch_q) begin
                st_q[fill_slot_i]   <= SL_FULL;
                data_q[fill_slot_i] <= fill_data_i;
            end
            if (pop_i) begin
                st_q[head_q]   <= SL_WANT;
                addr_q[head_q] <= addr_q[head_q] + LA_W'(DEPTH);
                head_q         <= head_q + SLOT_W'(1);
            end
        end
    end
endmodule

// File: rtl/spb_prefetch.sv
module spb_prefetch
    import spb_pkg::*;
#(
    parameter int NBUF    = 4,
    parameter int DEPTH   = 4,
    parameter int LA_W    = 26,
    parameter int DATA_W  = 64,
    parameter int EPOCH_W = 2,
    localparam int BUF_W  = idx_bits(NBUF),
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int ID_W   = BUF_W + SLOT_W + EPOCH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [LA_W-1:0]   miss_addr,
    output logic              miss_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [LA_W-1:0]   mem_req_addr,
    output logic [ID_W-1:0]   mem_req_id,
    input  logic              mem_rsp_valid,
    input  logic [ID_W-1:0]   mem_rsp_id,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    // Per-buffer views
    logic [NBUF-1:0]    head_live, head_full, want, hit_vec;
    logic [NBUF-1:0]    alloc, pop, issue, fill;
    logic [LA_W-1:0]    head_addr [NBUF];
    logic [DATA_W-1:0]  head_data [NBUF];
    logic [SLOT_W-1:0]  want_slot [NBUF];
    logic [LA_W-1:0]    want_addr [NBUF];
    logic [EPOCH_W-1:0] epoch     [NBUF];

    lk_st_e             lk_q;
    logic [BUF_W-1:0]   wait_idx_q;

    logic               accept, hit_any, want_any;
    logic [BUF_W-1:0]   hit_idx, want_idx, victim;

    logic [BUF_W-1:0]   fill_buf;
    logic [SLOT_W-1:0]  fill_slot;
    logic [EPOCH_W-1:0] fill_epoch;

    assign miss_ready = (lk_q == LK_IDLE);
    assign accept     = miss_valid && miss_ready;

    assign fill_buf   = mem_rsp_id[ID_W-1 -: BUF_W];
    assign fill_slot  = mem_rsp_id[EPOCH_W +: SLOT_W];
    assign fill_epoch = mem_rsp_id[EPOCH_W-1:0];

    // Head comparison
    always_comb begin
        for (int b = 0; b < NBUF; b++)
            hit_vec[b] = head_live[b] && (head_addr[b] == miss_addr);
    end

    spb_pick #(.N(NBUF)) hit_pick_i (
        .req_i (hit_vec),
        .any_o (hit_any),
        .idx_o (hit_idx)
    );

    spb_pick #(.N(NBUF)) req_pick_i (
        .req_i (want),
        .any_o (want_any),
        .idx_o (want_idx)
    );

    spb_lru #(.NBUF(NBUF)) lru_i (
        .clk         (clk),
        .rst         (rst),
        .touch_i     (accept),
        .touch_idx_i (hit_any ? hit_idx : victim),
        .victim_o    (victim)
    );

    // Per-buffer control strobes
    always_comb begin
        for (int b = 0; b < NBUF; b++) begin
            pop[b]   = ((lk_q == LK_IDLE) && accept && hit_any && hit_idx == BUF_W'(b) && head_full[b]) ||
                       ((lk_q == LK_WAIT) && wait_idx_q == BUF_W'(b) && head_full[b]);
            alloc[b] = accept && !hit_any && victim == BUF_W'(b);
            issue[b] = want_any && mem_req_ready && want_idx == BUF_W'(b);
            fill[b]  = mem_rsp_valid && fill_buf == BUF_W'(b);
        end
    end

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_buf
            spb_stream #(
                .LA_W    (LA_W),
                .DATA_W  (DATA_W),
                .DEPTH   (DEPTH),
                .EPOCH_W (EPOCH_W)
            ) stream_i (
                .clk          (clk),
                .rst          (rst),
                .alloc_i      (alloc[g]),
                .alloc_base_i (miss_addr + LA_W'(1)),
                .pop_i        (pop[g]),
                .issue_i      (issue[g]),
                .fill_i       (fill[g]),
                .fill_slot_i  (fill_slot),
                .fill_epoch_i (fill_epoch),
                .fill_data_i  (mem_rsp_data),
                .head_live_o  (head_live[g]),
                .head_full_o  (head_full[g]),
                .head_addr_o  (head_addr[g]),
                .head_data_o  (head_data[g]),
                .want_o       (want[g]),
                .want_slot_o  (want_slot[g]),
                .want_addr_o  (want_addr[g]),
                .epoch_o      (epoch[g])
            );
        end
    endgenerate

    assign mem_req_valid = want_any;
    assign mem_req_addr  = want_addr[want_idx];
    assign mem_req_id    = {want_idx, want_slot[want_idx], epoch[want_idx]};

    // Lookup engine and response register
    always_ff @(posedge clk) begin
        if (rst) begin
            lk_q       <= LK_IDLE;
            wait_idx_q <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (lk_q == LK_IDLE) begin
                if (accept) begin
                    if (hit_any && head_full[hit_idx]) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_data  <= head_data[hit_idx];
                    end else if (hit_any) begin
                        lk_q       <= LK_WAIT;
                        wait_idx_q <= hit_idx;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_data  <= '0;
                    end
                end
            end else if (head_full[wait_idx_q]) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b1;
                rsp_data  <= head_data[wait_idx_q];
                lk_q      <= LK_IDLE;
            end
        end
    end
endmodule

// File: rtl/spb_prefetch_chk.sv
module spb_prefetch_chk #(
    parameter int LA_W = 26
) (
    input logic            clk,
    input logic            rst,
    input logic            miss_valid,
    input logic            miss_ready,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            mem_req_valid,
    input logic [LA_W-1:0] mem_req_addr
);
    // R6: an answer is never given while a lookup is still held
    a_r6_ready_with_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> miss_ready);

    // R4: an accepted lookup is either answered next cycle or held
    a_r4_accept_next: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> (rsp_valid || !miss_ready));

    // R2: every answer traces back to an accepted or held lookup
    a_r2_rsp_origin: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(miss_valid && miss_ready) || $past(!miss_ready)));

    // R2: a miss answer is never delayed by a stall
    a_r2_miss_no_stall: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> $past(miss_valid && miss_ready));

    // R5: a presented request has a known line address
    a_r5_req_known: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !$isunknown(mem_req_addr));
endmodule

bind spb_prefetch spb_prefetch_chk #(.LA_W(LA_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/spb_prefetch_tb_top.sv
`timescale 1ns/1ps
module spb_prefetch_tb_top;
    localparam int NBUF = 2, DEPTH = 4, LA_W = 16, DATA_W = 16, EPOCH_W = 2;
    localparam int ID_W = 1 + 2 + EPOCH_W;

    logic clk = 1'b0;
    logic rst;
    logic miss_valid, miss_ready, rsp_valid, rsp_hit;
    logic [LA_W-1:0] miss_addr, mem_req_addr;
    logic [DATA_W-1:0] rsp_data, mem_rsp_data;
    logic mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [ID_W-1:0] mem_req_id, mem_rsp_id;

    always #2.5 clk = ~clk;

    spb_prefetch #(.NBUF(NBUF), .DEPTH(DEPTH), .LA_W(LA_W), .DATA_W(DATA_W), .EPOCH_W(EPOCH_W)) dut_i (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_id(mem_req_id),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_id(mem_rsp_id), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0, errors = 0;
    int req_cnt = 0, rsp_ptr = 0;
    bit auto_rsp = 0, done = 0;
    logic [LA_W-1:0] req_addr [0:1023];
    logic [ID_W-1:0] req_id   [0:1023];

    function automatic logic [DATA_W-1:0] line_val(input logic [LA_W-1:0] a);
        return a * 16'd7 + 16'h1234;
    endfunction

    function automatic int find_req(input logic [LA_W-1:0] a);
        int r = -1;
        for (int i = 0; i < req_cnt; i++) if (req_addr[i] == a) r = i;
        return r;
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: wait past the edge, answer older requests, then log the request on offer
    task automatic tick();
        @(posedge clk);
        #1;
        if (auto_rsp && rsp_ptr < req_cnt) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_id    = req_id[rsp_ptr];
            mem_rsp_data  = line_val(req_addr[rsp_ptr]);
            rsp_ptr++;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        if (mem_req_valid && mem_req_ready && req_cnt < 1024) begin
            req_addr[req_cnt] = mem_req_addr;
            req_id[req_cnt]   = mem_req_id;
            req_cnt++;
        end
    endtask

    task automatic deliver(input int idx);
        mem_rsp_valid = 1'b1;
        mem_rsp_id    = req_id[idx];
        mem_rsp_data  = line_val(req_addr[idx]);
    endtask

    task automatic drain();
        int n = 0;
        while ((rsp_ptr < req_cnt || mem_req_valid) && n < 200) begin
            tick();
            n++;
        end
        tick();
        tick();
    endtask

    task automatic lookup(input logic [LA_W-1:0] a, output bit hit, output logic [DATA_W-1:0] d, output int waited);
        miss_valid = 1'b1;
        miss_addr  = a;
        tick();
        miss_valid = 1'b0;
        waited = 0;
        while (!rsp_valid && waited < 100) begin
            tick();
            waited++;
        end
        hit = rsp_hit;
        d   = rsp_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit h;
        logic [DATA_W-1:0] d;
        int w, k, s;
        rst = 1'b1; miss_valid = 1'b0; miss_addr = '0; mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0; mem_rsp_id = '0; mem_rsp_data = '0;
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1
        check_eq("R1 miss_ready", int'(miss_ready), 1);
        check_eq("R1 rsp_valid", int'(rsp_valid), 0);
        check_eq("R1 mem_req_valid", int'(mem_req_valid), 0);

        // R2: first miss allocates buffer 0, epoch 1, lines +1..+4
        k = req_cnt;
        lookup(16'h0100, h, d, w);
        check_eq("R2 miss answer hit", int'(h), 0);
        check_eq("R2 miss answer latency", w, 0);
        repeat (4) tick();
        for (int i = 0; i < DEPTH; i++) begin
            check_eq("R2 request address", int'(req_addr[k+i]), 16'h0101 + i);
            check_eq("R2 request id", int'(req_id[k+i]), (0 << 4) | (i << 2) | 1);
        end

        // R4, R3, R5: head hit with data present
        auto_rsp = 1;
        drain();
        k = req_cnt;
        lookup(16'h0101, h, d, w);
        check_eq("R4 head hit", int'(h), 1);
        check_eq("R4 hit latency", w, 0);
        check_eq("R3 hit data", int'(d), int'(line_val(16'h0101)));
        tick();
        check_eq("R5 refill address", int'(req_addr[k]), 16'h0105);
        check_eq("R5 refill id", int'(req_id[k]), (0 << 4) | (0 << 2) | 1);
        drain();

        // R7: non-head entry does not hit; buffer 1 allocated at +1
        k = req_cnt;
        lookup(16'h0103, h, d, w);
        check_eq("R7 non-head is a miss", int'(h), 0);
        repeat (4) tick();
        check_eq("R7 new stream address", int'(req_addr[k]), 16'h0104);
        check_eq("R7 new stream id", int'(req_id[k]), (1 << 4) | (0 << 2) | 1);
        drain();

        // R9: both buffers answer
        lookup(16'h0102, h, d, w);
        check_eq("R9 stream0 hit", int'(h), 1);
        check_eq("R9 stream0 data", int'(d), int'(line_val(16'h0102)));
        lookup(16'h0104, h, d, w);
        check_eq("R9 stream1 hit", int'(h), 1);
        check_eq("R9 stream1 data", int'(d), int'(line_val(16'h0104)));
        drain();

        // R6: stalled head hit, timed to the fill edge
        auto_rsp = 0;
        lookup(16'h0200, h, d, w);
        check_eq("R6 setup miss", int'(h), 0);
        miss_valid = 1'b1; miss_addr = 16'h0201;
        tick();
        miss_valid = 1'b0;
        check_eq("R6 no answer yet", int'(rsp_valid), 0);
        check_eq("R6 lookup held", int'(miss_ready), 0);
        k = 0;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (rsp_valid || miss_ready) k++;
        end
        check_eq("R6 held while fill absent", k, 0);
        deliver(find_req(16'h0201));
        tick();
        check_eq("R6 answer not at fill edge", int'(rsp_valid), 0);
        tick();
        check_eq("R6 answer one edge after fill", int'(rsp_valid), 1);
        check_eq("R6 answer is hit", int'(rsp_hit), 1);
        check_eq("R6 answer data", int'(rsp_data), int'(line_val(16'h0201)));
        repeat (3) tick();

        // R8: stale fill into the reused slot is dropped
        lookup(16'h0300, h, d, w);
        check_eq("R8 setup miss a", int'(h), 0);
        lookup(16'h0500, h, d, w);
        check_eq("R8 setup miss b", int'(h), 0);
        repeat (10) tick();
        s = find_req(16'h0205);
        check_eq("R8 stale id", int'(req_id[s]), (0 << 4) | (0 << 2) | 2);
        deliver(s);
        tick();
        miss_valid = 1'b1; miss_addr = 16'h0501;
        tick();
        miss_valid = 1'b0;
        check_eq("R8 stale fill ignored, no answer", int'(rsp_valid), 0);
        check_eq("R8 stale fill ignored, held", int'(miss_ready), 0);
        tick();
        tick();
        check_eq("R8 still held", int'(miss_ready), 0);
        deliver(find_req(16'h0501));
        tick();
        tick();
        check_eq("R8 answer after true fill", int'(rsp_valid), 1);
        check_eq("R8 answer data", int'(rsp_data), int'(line_val(16'h0501)));

        // R3, R5: single stream sweep
        rsp_ptr = req_cnt;
        auto_rsp = 1;
        lookup(16'h0600, h, d, w);
        check_eq("R2 sweep first miss", int'(h), 0);
        for (int i = 1; i <= 20; i++) begin
            lookup(16'h0600 + 16'(i), h, d, w);
            check_eq("R5 sweep hit", int'(h), 1);
            check_eq("R3 sweep data", int'(d), int'(line_val(16'h0600 + 16'(i))));
        end

        // R9: two interleaved streams
        lookup(16'h0700, h, d, w);
        check_eq("R9 stream a first miss", int'(h), 0);
        lookup(16'h0900, h, d, w);
        check_eq("R9 stream b first miss", int'(h), 0);
        for (int i = 1; i <= 12; i++) begin
            lookup(16'h0700 + 16'(i), h, d, w);
            check_eq("R9 stream a hit", int'(h), 1);
            check_eq("R9 stream a data", int'(d), int'(line_val(16'h0700 + 16'(i))));
            lookup(16'h0900 + 16'(i), h, d, w);
            check_eq("R9 stream b hit", int'(h), 1);
            check_eq("R9 stream b data", int'(d), int'(line_val(16'h0900 + 16'(i))));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule